// File: doc/BRIEF.md
# Trigger Endpoint Receive Handler

This block sits at a detector endpoint between the network side, which delivers one 64-bit trigger information word per trigger, and the local readout logic. It keeps a running count of the fast trigger strobes that arrive on a dedicated input. When an information word arrives, the block splits it into type, number, random code and information fields. It then raises a received flag and holds the fields steady until the readout logic answers with a release.

When the word is accepted, the trigger number it carries is compared with the local strobe count. If the two disagree, or if no strobe has arrived since the previous word, a mismatch bit is set in the error pattern. The trigger is released in every case. The error pattern is the locally supplied pattern with the mismatch bit ORed in. It is presented with a one-cycle release pulse, in the same cycle in which the received flag drops. A control bit clears the strobe counter so that the network controller can resynchronise the endpoint.

Top module: `trg_rx_endpoint`

## Requirements
- R1: In the accepted word, bits 3:0 appear on `trg_type_o`, bits 31:16 on `trg_num_o`, bits 39:32 on `trg_rnd_o` and bits 63:40 on `trg_info_o`. Bits 15:4 are not used.
- R2: A word offered with `pkt_valid_i` high while `trg_rcv_o` is low is accepted at that clock edge, and `trg_rcv_o` is high from the next cycle on.
- R3: While `trg_rcv_o` is high and no release has been seen, all four field outputs stay unchanged.
- R4: When `rel_i` is high while `trg_rcv_o` is high, `trg_rcv_o` is low in the next cycle. In that same cycle `rel_done_o` is high for exactly one cycle.
- R5: Each clock cycle with `strobe_i` high adds one to a 16-bit strobe counter, which wraps from 65535 to 0.
- R6: The trigger number is compared with the counter value that includes any strobe in the acceptance cycle. On a difference, bit 16 of `err_pat_o` is set. On equality it stays clear.
- R7: `err_pat_o` shown with `rel_done_o` equals `err_local_i` sampled in the release cycle, ORed with the mismatch bit at position 16.
- R8: A word accepted when no strobe has been seen since the previous accepted word sets the mismatch bit, whatever its number is. It is otherwise handled normally.
- R9: A cycle with `cnt_clr_i` high sets the strobe counter to zero, and this takes priority over a strobe in the same cycle. The next strobe then matches trigger number 1.
- R10: A word offered while `trg_rcv_o` is high is ignored. The outputs do not change, and no second received phase follows the release.
- R11: After reset, `trg_rcv_o`, `rel_done_o` and `err_pat_o` are zero and the strobe counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Fast trigger strobe, one count per cycle high, synchronous |
| cnt_clr_i | input | 1 | Control-register bit that clears the strobe counter |
| pkt_valid_i | input | 1 | Trigger information word valid |
| pkt_word_i | input | 64 | Trigger information word |
| rel_i | input | 1 | Release from the readout logic |
| err_local_i | input | 32 | Locally supplied error pattern |
| trg_rcv_o | output | 1 | Trigger received, fields valid |
| trg_type_o | output | 4 | Trigger type |
| trg_num_o | output | 16 | Trigger number |
| trg_rnd_o | output | 8 | Random code |
| trg_info_o | output | 24 | Additional information |
| rel_done_o | output | 1 | One-cycle pulse marking the release |
| err_pat_o | output | 32 | Error pattern sent back with the release |

## Verification
Most words are drawn at random with a numbering that follows the strobes, so the bench can confirm that field slicing and a clean error pattern hold across many field values. Some words carry a deliberately wrong number, and some come with no preceding strobe. These separate the two causes of the mismatch bit and show whether the comparison uses the post-strobe count. Directed cases clear the counter, hold the strobe high for a full wrap to number 0, and offer a second word during a received phase. Together they separate clear priority, 16-bit wrap and the rule that words are ignored while busy.

// File: rtl/trg_rx_pkg.sv
package trg_rx_pkg;
  localparam int WORD_W  = 64;
  localparam int TYPE_W  = 4;
  localparam int NUM_W   = 16;
  localparam int RND_W   = 8;
  localparam int INFO_W  = 24;
  localparam int TYPE_LO = 0;
  localparam int NUM_LO  = 16;
  localparam int RND_LO  = 32;
  localparam int INFO_LO = 40;

  typedef struct packed {
    logic [INFO_W-1:0] info;
    logic [RND_W-1:0]  rnd;
    logic [NUM_W-1:0]  num;
    logic [TYPE_W-1:0] ttype;
  } trg_fields_t;

  typedef enum logic {HS_IDLE = 1'b0, HS_BUSY = 1'b1} hs_state_t;
endpackage

// File: rtl/trg_word_unpack.sv
module trg_word_unpack
  import trg_rx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output trg_fields_t       fields_o
);
  logic unused_bits;
  assign unused_bits = ^word_i[NUM_LO-1:TYPE_LO+TYPE_W];

  always_comb begin
    fields_o.ttype = word_i[TYPE_LO +: TYPE_W];
    fields_o.num   = word_i[NUM_LO  +: NUM_W];
    fields_o.rnd   = word_i[RND_LO  +: RND_W];
    fields_o.info  = word_i[INFO_LO +: INFO_W];
  end
endmodule

// File: rtl/trg_strobe_cnt.sv
module trg_strobe_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             clr_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic             pend_eff_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, pend_nx;
  logic             cnt_en;

  always_comb begin
    cnt_en     = clr_i | strobe_i;
    cnt_nx_o   = cnt_q;
    if (clr_i)         cnt_nx_o = '0;
    else if (strobe_i) cnt_nx_o = cnt_q + CNT_W'(1);
    pend_eff_o = pend_q | strobe_i;
    pend_nx    = take_i ? 1'b0 : pend_eff_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_nx_o;
      pend_q <= pend_nx;
    end
  end

  assign cnt_q_o = cnt_q;
endmodule

// File: rtl/trg_handshake.sv
module trg_handshake
  import trg_rx_pkg::*;
#(
  parameter int ERR_W   = 32,
  parameter int MIS_BIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid_i,
  input  trg_fields_t fields_i,
  input  logic        mismatch_i,
  input  logic        rel_i,
  input  logic [ERR_W-1:0] err_local_i,
  output logic        take_o,
  output logic        rcv_o,
  output trg_fields_t fields_o,
  output logic        rel_done_o,
  output logic [ERR_W-1:0] err_pat_o
);
  localparam logic [ERR_W-1:0] MIS_MASK = ERR_W'(1) << MIS_BIT;

  hs_state_t        st_q, st_nx;
  trg_fields_t      fld_q;
  logic             mis_q;
  logic             done_nx, done_q;
  logic             err_en;
  logic [ERR_W-1:0] err_nx, err_q;

  always_comb begin
    st_nx   = st_q;
    take_o  = 1'b0;
    done_nx = 1'b0;
    err_en  = 1'b0;
    err_nx  = err_local_i | (mis_q ? MIS_MASK : '0);
    case (st_q)
      HS_IDLE: if (pkt_valid_i) begin
        take_o = 1'b1;
        st_nx  = HS_BUSY;
      end
      HS_BUSY: if (rel_i) begin
        done_nx = 1'b1;
        err_en  = 1'b1;
        st_nx   = HS_IDLE;
      end
      default: st_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      fld_q  <= '0;
      mis_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= '0;
    end else begin
      st_q   <= st_nx;
      done_q <= done_nx;
      if (take_o) begin
        fld_q <= fields_i;
        mis_q <= mismatch_i;
      end
      if (err_en) err_q <= err_nx;
    end
  end

  assign rcv_o      = (st_q == HS_BUSY);
  assign fields_o   = fld_q;
  assign rel_done_o = done_q;
  assign err_pat_o  = err_q;
endmodule

// File: rtl/trg_rx_endpoint.sv
module trg_rx_endpoint
  import trg_rx_pkg::*;
#(
  parameter int ERR_W   = 32,
  parameter int MIS_BIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic               cnt_clr_i,
  input  logic               pkt_valid_i,
  input  logic [WORD_W-1:0]  pkt_word_i,
  input  logic               rel_i,
  input  logic [ERR_W-1:0]   err_local_i,
  output logic               trg_rcv_o,
  output logic [TYPE_W-1:0]  trg_type_o,
  output logic [NUM_W-1:0]   trg_num_o,
  output logic [RND_W-1:0]   trg_rnd_o,
  output logic [INFO_W-1:0]  trg_info_o,
  output logic               rel_done_o,
  output logic [ERR_W-1:0]   err_pat_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ns;
  trg_fields_t      fld_in, fld_out;
  logic             take;
  logic [NUM_W-1:0] cnt_nx, cnt_q;
  logic             pend_eff;
  logic             mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  trg_word_unpack i_unpack (
    .word_i   (pkt_word_i),
    .fields_o (fld_in)
  );

  trg_strobe_cnt #(.CNT_W(NUM_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_ns),
    .strobe_i   (strobe_i),
    .clr_i      (cnt_clr_i),
    .take_i     (take),
    .cnt_nx_o   (cnt_nx),
    .cnt_q_o    (cnt_q),
    .pend_eff_o (pend_eff)
  );

  assign mismatch = (fld_in.num != cnt_nx) | ~pend_eff;

  trg_handshake #(.ERR_W(ERR_W), .MIS_BIT(MIS_BIT)) i_hs (
    .clk         (clk),
    .rst_n       (rst_ns),
    .pkt_valid_i (pkt_valid_i),
    .fields_i    (fld_in),
    .mismatch_i  (mismatch),
    .rel_i       (rel_i),
    .err_local_i (err_local_i),
    .take_o      (take),
    .rcv_o       (trg_rcv_o),
    .fields_o    (fld_out),
    .rel_done_o  (rel_done_o),
    .err_pat_o   (err_pat_o)
  );

  assign trg_type_o = fld_out.ttype;
  assign trg_num_o  = fld_out.num;
  assign trg_rnd_o  = fld_out.rnd;
  assign trg_info_o = fld_out.info;
endmodule

// File: rtl/trg_rx_checker.sv
module trg_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        strobe_i,
  input logic        cnt_clr_i,
  input logic        pkt_valid_i,
  input logic        rel_i,
  input logic        trg_rcv_o,
  input logic [3:0]  trg_type_o,
  input logic [15:0] trg_num_o,
  input logic [7:0]  trg_rnd_o,
  input logic [23:0] trg_info_o,
  input logic        rel_done_o,
  input logic [15:0] cnt_q
);
  // R2
  rcv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && !trg_rcv_o) |=> trg_rcv_o);

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_rcv_o && !rel_i) |=> (trg_rcv_o && $stable(trg_num_o) && $stable(trg_type_o)
                               && $stable(trg_rnd_o) && $stable(trg_info_o)));

  // R4
  rcv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_rcv_o && rel_i) |=> (!trg_rcv_o && rel_done_o));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done_o |=> !rel_done_o);

  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done_o |-> !trg_rcv_o);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !cnt_clr_i) |=> (cnt_q == 16'($past(cnt_q) + 16'd1)));

  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_q == 16'd0));
endmodule

bind trg_rx_endpoint trg_rx_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_ns),
  .strobe_i    (strobe_i),
  .cnt_clr_i   (cnt_clr_i),
  .pkt_valid_i (pkt_valid_i),
  .rel_i       (rel_i),
  .trg_rcv_o   (trg_rcv_o),
  .trg_type_o  (trg_type_o),
  .trg_num_o   (trg_num_o),
  .trg_rnd_o   (trg_rnd_o),
  .trg_info_o  (trg_info_o),
  .rel_done_o  (rel_done_o),
  .cnt_q       (cnt_q)
);

// File: tb/test_trg_rx_endpoint.sv
`timescale 1ns/1ps
module test_trg_rx_endpoint;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i, cnt_clr_i, pkt_valid_i, rel_i;
  logic [63:0] pkt_word_i;
  logic [31:0] err_local_i;
  logic        trg_rcv_o, rel_done_o;
  logic [3:0]  trg_type_o;
  logic [15:0] trg_num_o;
  logic [7:0]  trg_rnd_o;
  logic [23:0] trg_info_o;
  logic [31:0] err_pat_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] m_cnt;
  logic        m_pend;

  always #2.5 clk = ~clk;

  trg_rx_endpoint i_trg_rx_endpoint (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .cnt_clr_i(cnt_clr_i),
    .pkt_valid_i(pkt_valid_i), .pkt_word_i(pkt_word_i), .rel_i(rel_i),
    .err_local_i(err_local_i), .trg_rcv_o(trg_rcv_o), .trg_type_o(trg_type_o),
    .trg_num_o(trg_num_o), .trg_rnd_o(trg_rnd_o), .trg_info_o(trg_info_o),
    .rel_done_o(rel_done_o), .err_pat_o(err_pat_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_err(input logic [31:0] loc, input bit mis);
    return loc | (mis ? 32'h0001_0000 : 32'h0);
  endfunction

  function automatic logic [63:0] make_word(input logic [23:0] info, input logic [7:0] rnd,
                                            input logic [15:0] num, input logic [3:0] ty);
    return {info, rnd, num, 12'($urandom), ty};
  endfunction

  task automatic strobe_once();
    strobe_i = 1'b1; tick(); strobe_i = 1'b0;
    m_cnt = m_cnt + 16'd1; m_pend = 1'b1;
  endtask

  task automatic clear_cnt();
    cnt_clr_i = 1'b1; tick(); cnt_clr_i = 1'b0;
    m_cnt = 16'd0;
  endtask

  // full trigger: optional strobe, word, hold, release
  task automatic trigger(input bit do_strobe, input logic [15:0] num, input int gap,
                         input bit busy_word);
    logic [23:0] info; logic [7:0] rnd; logic [3:0] ty; logic [31:0] loc; bit mis;
    info = 24'($urandom); rnd = 8'($urandom); ty = 4'($urandom); loc = $urandom;
    loc[16] = 1'b0;
    if (do_strobe) strobe_once();
    for (int i = 0; i < gap; i++) tick();
    pkt_word_i = make_word(info, rnd, num, ty);
    pkt_valid_i = 1'b1; tick(); pkt_valid_i = 1'b0;
    mis = !m_pend || (num != m_cnt);
    m_pend = 1'b0;
    check(trg_rcv_o == 1'b1, "R2", 64'(trg_rcv_o), 64'd1);
    check(trg_num_o == num && trg_type_o == ty && trg_rnd_o == rnd && trg_info_o == info,
          "R1", {trg_info_o, trg_rnd_o, trg_num_o, 12'h0, trg_type_o},
          {info, rnd, num, 12'h0, ty});
    if (busy_word) begin
      pkt_word_i = make_word(~info, ~rnd, ~num, ~ty);
      pkt_valid_i = 1'b1; tick(); pkt_valid_i = 1'b0;
      check(trg_num_o == num && trg_info_o == info && trg_rcv_o, "R10",
            64'(trg_num_o), 64'(num));
    end
    for (int i = 0; i < gap; i++) tick();
    check(trg_rcv_o && trg_num_o == num && trg_type_o == ty, "R3",
          64'(trg_num_o), 64'(num));
    rel_i = 1'b1; err_local_i = loc; tick(); rel_i = 1'b0; err_local_i = $urandom;
    check(!trg_rcv_o && rel_done_o, "R4", {62'h0, trg_rcv_o, rel_done_o}, 64'd1);
    check(err_pat_o[16] == mis, mis ? "R6/R8 mismatch" : "R6 match",
          64'(err_pat_o[16]), 64'(mis));
    check(err_pat_o == exp_err(loc, mis), "R7", 64'(err_pat_o), 64'(exp_err(loc, mis)));
    tick();
    check(!rel_done_o && !trg_rcv_o, "R4 R10 single", {62'h0, trg_rcv_o, rel_done_o}, 64'd0);
  endtask

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; strobe_i = 0; cnt_clr_i = 0; pkt_valid_i = 0; rel_i = 0;
    pkt_word_i = '0; err_local_i = '0;
    m_cnt = 0; m_pend = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R11 reset state
    check(!trg_rcv_o && !rel_done_o && err_pat_o == 32'h0, "R11",
          {31'h0, trg_rcv_o, err_pat_o}, 64'd0);
    // R11: first strobe after reset matches number 1
    trigger(1'b1, 16'd1, 1, 1'b0);
    // R8: no strobe pending, number that would otherwise match
    trigger(1'b0, m_cnt, 2, 1'b0);
    // R10: word offered while busy
    trigger(1'b1, m_cnt + 16'd1, 2, 1'b1);
    // R9: clear then next strobe matches 1; clear wins over strobe
    clear_cnt();
    trigger(1'b1, 16'd1, 0, 1'b0);
    strobe_i = 1'b1; cnt_clr_i = 1'b1; tick(); strobe_i = 1'b0; cnt_clr_i = 1'b0;
    m_cnt = 16'd0; m_pend = 1'b1;
    trigger(1'b0, 16'd0, 1, 1'b0);   // R9 priority: count stays 0
    // random traffic, R5 R6 R7
    for (int k = 0; k < 60; k++) begin
      bit st; logic [15:0] n;
      st = ($urandom % 10) != 0;
      n = (($urandom % 10) < 7) ? m_cnt + (st ? 16'd1 : 16'd0) : 16'($urandom);
      trigger(st, n, int'($urandom % 4), ($urandom % 8) == 0);
    end
    // R5 wrap: 65536 strobe cycles return the count to 0
    clear_cnt();
    strobe_i = 1'b1;
    for (int i = 0; i < 65536; i++) tick();
    strobe_i = 1'b0;
    m_cnt = 16'd0; m_pend = 1'b1;
    trigger(1'b0, 16'd0, 1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule